// File: doc/BRIEF.md
# DAC Sample Holding and Trigger Transfer Front End

This block is the digital side of one digital-to-analog converter channel. Software writes a sample through a small register port in one of three alignments: 12 bits justified to the low end, 12 bits justified to the high end of a 16-bit word, or 8 bits justified to the low end. Every format is normalized into one 12-bit holding register. The value in the holding register then moves into an output register, and that output register drives the converter code pins.

The move happens in one of two ways. With triggering off, each data write is followed one clock later by a copy into the output register. With triggering on, the copy waits for a trigger and then happens three clocks after it. The trigger comes from a self-clearing software trigger bit or from a rising edge on an external event input, depending on a source-select control bit. A channel-enable bit only drives the converter power pin. Register writes and transfers carry on whether it is set or not.

Register map (3-bit address): 0 control, with bit0 channel enable, bit1 trigger enable and bit2 trigger source (0 software, 1 external); 1 software trigger (write bit0 = 1 to set; reads back the pending bit in bit0); 2 data, 12-bit low-justified (bits [11:0]); 3 data, 12-bit high-justified (bits [15:4]); 4 data, 8-bit low-justified (bits [7:0]); 5 output code, read-only. Reads of addresses 2, 3 and 4 return the holding register in that address's alignment. Unused addresses read as zero.

Top module: `dac_fe_top`

## Requirements
- R1: A write to address 2 loads holding[11:0] from write data bits [11:0]. Bits [15:12] are discarded.
- R2: A write to address 3 loads holding[11:0] from write data bits [15:4]. Bits [3:0] are discarded.
- R3: A write to address 4 loads holding[11:4] from write data bits [7:0] and clears holding[3:0]. Address 4 reads back holding[11:4] in bits [7:0].
- R4: With trigger enable 0, the output code still shows its old value after the clock edge that captures a data write. It equals the new holding value after the next edge.
- R5: With trigger enable 1 and source external, a data write does not change the output. An external rising edge sampled at edge t makes the output take the holding value at edge t+3 and not earlier.
- R6: Writing 1 to bit0 of address 1 at edge w sets the software trigger bit. With trigger enable 1 and source software, the output is updated at edge w+4, and the bit reads 0 afterwards.
- R7: A trigger that arrives while a triggered transfer is pending is ignored. The transfer copies the holding value present at the edge where it executes.
- R8: The output register has no write path. A write to address 5 leaves both the code and the address 5 readback unchanged.
- R9: The converter enable output follows control bit0. Transfers work the same whether it is 0 or 1.
- R10: After reset, the output code, the holding register, the control bits, the software trigger bit and the converter enable all read 0.
- R11: With source software, external edges start no transfer. With source external, a set software trigger bit starts no transfer and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Combinational read data |
| ext_trig | input | 1 | External trigger event (synchronous; rising edge counts) |
| conv_en | output | 1 | Converter power enable |
| conv_code | output | 12 | Code driven to the converter |

## Verification
The hardest case to reach from the ports is a triggered transfer that is already pending while both a second trigger and a new data write arrive inside its three-cycle window. The bench places an external pulse, then a data write, then a second pulse on consecutive cycles. It checks that the output takes the late-written value at exactly the third edge after the first pulse. It then writes a different value and watches for several more cycles to confirm that no second transfer follows.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int unsigned CODE_W = 12;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 3'd0,
        ADR_SWTRIG = 3'd1,
        ADR_D12R   = 3'd2,
        ADR_D12L   = 3'd3,
        ADR_D8R    = 3'd4,
        ADR_OUT    = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic src_ext;
        logic trig_en;
        logic chan_en;
    } ctrl_t;

    function automatic logic is_data_addr(input logic [ADDR_W-1:0] a);
        return (a == ADR_D12R) || (a == ADR_D12L) || (a == ADR_D8R);
    endfunction

    function automatic logic [CODE_W-1:0] align_sample(
        input logic [ADDR_W-1:0] a,
        input logic [BUS_W-1:0]  d
    );
        logic [CODE_W-1:0] r;
        case (a)
            ADR_D12L: r = d[BUS_W-1 -: CODE_W];
            ADR_D8R:  r = {d[7:0], {(CODE_W-8){1'b0}}};
            default:  r = d[CODE_W-1:0];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
    import dac_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              sw_clr,
    output ctrl_t             ctrl_q,
    output logic [CODE_W-1:0] hold_q,
    output logic              sw_bit_q,
    output logic              data_wr
);

    assign data_wr = wr_en && is_data_addr(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            hold_q   <= '0;
            sw_bit_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADR_CTRL)
                ctrl_q <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
            if (data_wr)
                hold_q <= align_sample(wr_addr, wr_data);
            if (wr_en && wr_addr == ADR_SWTRIG && wr_data[0])
                sw_bit_q <= 1'b1;
            else if (sw_clr)
                sw_bit_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dac_fe_xfer.sv
module dac_fe_xfer
    import dac_fe_pkg::*;
#(
    parameter int unsigned TRIG_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [CODE_W-1:0] hold,
    input  logic              sw_bit,
    input  logic              ext_trig,
    input  logic              data_wr,
    output logic [CODE_W-1:0] out_q,
    output logic              busy_q,
    output logic              fire,
    output logic              sw_done
);

    localparam int unsigned CW = (TRIG_LAT > 1) ? $clog2(TRIG_LAT) : 1;

    logic          ext_q;
    logic          auto_q;
    logic          armed_sw_q;
    logic [CW-1:0] cnt_q;
    logic          ext_evt, sw_evt, arm;

    assign ext_evt = ext_trig && !ext_q && ctrl.src_ext;
    assign sw_evt  = sw_bit && !ctrl.src_ext;
    assign arm     = ctrl.trig_en && !busy_q && (ext_evt || sw_evt);
    assign fire    = busy_q && (cnt_q == '0);
    assign sw_done = fire && armed_sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q      <= 1'b0;
            auto_q     <= 1'b0;
            armed_sw_q <= 1'b0;
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            out_q      <= '0;
        end else begin
            ext_q  <= ext_trig;
            auto_q <= data_wr && !ctrl.trig_en;
            if (fire || auto_q)
                out_q <= hold;
            if (arm) begin
                busy_q     <= 1'b1;
                cnt_q      <= CW'(TRIG_LAT - 1);
                armed_sw_q <= sw_evt;
            end else if (fire) begin
                busy_q     <= 1'b0;
                armed_sw_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/dac_fe_top.sv
module dac_fe_top
    import dac_fe_pkg::*;
#(
    parameter int unsigned TRIG_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BUS_W-1:0]  rd_data,
    input  logic              ext_trig,
    output logic              conv_en,
    output logic [CODE_W-1:0] conv_code
);

    ctrl_t             ctrl_q;
    logic [CODE_W-1:0] hold_q;
    logic              sw_bit_q;
    logic              data_wr;
    logic              busy_q;
    logic              fire;
    logic              sw_done;

    dac_fe_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sw_clr   (sw_done),
        .ctrl_q   (ctrl_q),
        .hold_q   (hold_q),
        .sw_bit_q (sw_bit_q),
        .data_wr  (data_wr)
    );

    dac_fe_xfer #(.TRIG_LAT(TRIG_LAT)) u_xfer (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl_q),
        .hold     (hold_q),
        .sw_bit   (sw_bit_q),
        .ext_trig (ext_trig),
        .data_wr  (data_wr),
        .out_q    (conv_code),
        .busy_q   (busy_q),
        .fire     (fire),
        .sw_done  (sw_done)
    );

    assign conv_en = ctrl_q.chan_en;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_CTRL:   rd_data = BUS_W'(ctrl_q);
            ADR_SWTRIG: rd_data = BUS_W'(sw_bit_q);
            ADR_D12R:   rd_data = BUS_W'(hold_q);
            ADR_D12L:   rd_data = {hold_q, {(BUS_W-CODE_W){1'b0}}};
            ADR_D8R:    rd_data = BUS_W'(hold_q[CODE_W-1 -: 8]);
            ADR_OUT:    rd_data = BUS_W'(conv_code);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker
    import dac_fe_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input ctrl_t             ctrl_q,
    input logic [CODE_W-1:0] hold_q,
    input logic              sw_bit_q,
    input logic              busy_q,
    input logic              fire,
    input logic [CODE_W-1:0] conv_code
);

    a_r3_low_nibble_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADR_D8R) |=> (hold_q[3:0] == 4'd0));

    a_r4_auto_copy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_data_addr(wr_addr) && !ctrl_q.trig_en && !busy_q)
        |=> ##1 (conv_code == $past(hold_q)));

    a_r8_out_from_hold: assert property (@(posedge clk) disable iff (rst)
        (conv_code != $past(conv_code)) |-> (conv_code == $past(hold_q)));

    a_r5_no_early_update: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |=> $stable(conv_code));

    a_r6_sw_clear_on_fire: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_bit_q) |-> $past(fire));

endmodule

bind dac_fe_top dac_fe_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .ctrl_q    (ctrl_q),
    .hold_q    (hold_q),
    .sw_bit_q  (sw_bit_q),
    .busy_q    (busy_q),
    .fire      (fire),
    .conv_code (conv_code)
);

// File: tb/dac_fe_top_tb_top.sv
`timescale 1ns/1ps
module dac_fe_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ext_trig = 1'b0;
    logic        conv_en;
    logic [11:0] conv_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dac_fe_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_trig(ext_trig), .conv_en(conv_en), .conv_code(conv_code)
    );

    // {address, write data, expected holding value}
    localparam int NV = 7;
    localparam logic [30:0] VEC [NV] = '{
        {3'd2, 16'h0ABC, 12'hABC},   // R1
        {3'd2, 16'hF123, 12'h123},   // R1 upper bits dropped
        {3'd3, 16'hABCD, 12'hABC},   // R2
        {3'd3, 16'h000F, 12'h000},   // R2 low bits dropped
        {3'd4, 16'h12A5, 12'hA50},   // R3
        {3'd4, 16'h00FF, 12'hFF0},   // R3
        {3'd3, 16'hFFF0, 12'hFFF}    // R2 full scale
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ext();
        ext_trig = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        logic [15:0] v;
        logic [11:0] prev;
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check("R10 code", {4'd0, conv_code}, 16'd0);
        check("R10 conv_en", {15'd0, conv_en}, 16'd0);
        rd(3'd0, v); check("R10 ctrl", v, 16'd0);
        rd(3'd2, v); check("R10 hold", v, 16'd0);
        rd(3'd1, v); check("R10 swbit", v, 16'd0);

        // Format table, trigger off, channel disabled (R9 transfers still run)
        for (int i = 0; i < NV; i++) begin
            prev = conv_code;
            wr(VEC[i][30:28], VEC[i][27:12]);
            rd(3'd2, v); check("R1/R2/R3 hold", v, {4'd0, VEC[i][11:0]});
            check("R4 no copy yet", {4'd0, conv_code}, {4'd0, prev});
            @(negedge clk);
            check("R4 R9 copied", {4'd0, conv_code}, {4'd0, VEC[i][11:0]});
        end
        rd(3'd3, v); check("R2 readback", v, 16'hFFF0);
        wr(3'd4, 16'h003C);
        rd(3'd4, v); check("R3 readback", v, 16'h003C);
        rd(3'd2, v); check("R3 low nibble", v, 16'h03C0);
        @(negedge clk);

        // R8 output not writable
        wr(3'd5, 16'h0123);
        idle(2);
        rd(3'd5, v); check("R8 readback", v, 16'h03C0);
        check("R8 code", {4'd0, conv_code}, 16'h03C0);

        // R5 triggered, external source
        wr(3'd0, 16'h0006);
        wr(3'd2, 16'h0555);
        idle(3);
        check("R5 write no effect", {4'd0, conv_code}, 16'h03C0);
        pulse_ext();                              // edge t
        idle(2);                                  // after t+2
        check("R5 not early", {4'd0, conv_code}, 16'h03C0);
        @(negedge clk);                           // after t+3
        check("R5 at t+3", {4'd0, conv_code}, 16'h0555);

        // R7 retrigger ignored, late data taken
        idle(2);
        pulse_ext();                              // edge t
        wr(3'd2, 16'h0777);                       // edge t+1
        pulse_ext();                              // edge t+2, ignored
        @(negedge clk);                           // after t+3
        check("R7 late data", {4'd0, conv_code}, 16'h0777);
        wr(3'd2, 16'h0999);                       // edge t+4
        idle(5);
        check("R7 no second transfer", {4'd0, conv_code}, 16'h0777);

        // R11 software bit ignored under external source
        wr(3'd1, 16'h0001);
        rd(3'd1, v); check("R6 bit set", v, 16'h0001);
        idle(6);
        check("R11 sw ignored", {4'd0, conv_code}, 16'h0777);
        rd(3'd1, v); check("R11 bit kept", v, 16'h0001);

        // R6 switch to software source: write at edge w, transfer at w+4
        wr(3'd0, 16'h0002);                       // edge w
        idle(3);                                  // after w+3
        check("R6 not early", {4'd0, conv_code}, 16'h0777);
        @(negedge clk);                           // after w+4
        check("R6 at w+4", {4'd0, conv_code}, 16'h0999);
        rd(3'd1, v); check("R6 bit cleared", v, 16'h0000);

        // R11 external edges ignored under software source
        wr(3'd2, 16'h0AAA);
        pulse_ext();
        idle(6);
        check("R11 ext ignored", {4'd0, conv_code}, 16'h0999);

        // R9 enable pin follows bit0 only
        wr(3'd0, 16'h0001);
        check("R9 conv_en", {15'd0, conv_en}, 16'd1);
        wr(3'd2, 16'h0BCD);
        @(negedge clk);
        check("R9 transfer with enable", {4'd0, conv_code}, 16'h0BCD);

        done = 1'b1;
        report();
    end

endmodule